// File: doc/BRIEF.md
# Self-Selecting Bus Priority Contender

This block is one contender in an arbitration scheme with no central arbiter. Every contender that wants the bus drives its own 4-bit priority code onto four shared open-drain lines. Because the lines form a wired-AND, the smallest code being driven is the value that settles on them. Each contender reads the resolved lines on four separate inputs, compares them with its own code, and decides by itself whether it has won.

The block does not model the physical lines. It produces one pull-down enable per line for external open-drain buffers. A strobe from the bus master marks the arbitration window. When the strobe falls, the block latches its result into a grant output and a lost output. A request is taken as a pulse and is remembered: a contender that loses competes again in the next window without further action.

The parameter `FLIP` lets a bench build a contender whose driven pattern differs from the level it compares against. It defaults to zero.

Top module: `prio_arb_node`

## Requirements
- R1: After reset, `pull_low`, `grant` and `lost` are all zero.
- R2: `pull_low` is nonzero only while `arb_phase` is high and a request is present, either `req` this cycle or one still pending.
- R3: While contending, line i is pulled low (`pull_low[i]=1`) only where bit i of the driven level is 0.
- R4: A bit is released when a more significant bit that the contender drives as 1 was sensed as 0 in the previous cycle. This is re-evaluated every cycle, so the lines settle to the lowest driven level within four cycles.
- R5: Among contenders with distinct levels, only the one with the lowest level is granted. Every other contender reports lost.
- R6: `grant` and `lost` change only on the clock edge that follows the cycle in which `arb_phase` falls. Between those edges they hold their value, including through the next window.
- R7: A contender wins only if the sensed lines, in the last cycle of the window, equal its configured `level` (bit i of `level` compares with `line_in[i]`).
- R8: A contender that took part in the window sets exactly one of `grant` or `lost`. A contender that did not take part sets neither.
- R9: The level 4'b1111 equals the idle value of the lines and is never granted.
- R10: A pulse on `req` stays pending until the contender is granted. A contender that lost competes again in the next window with `req` low.
- R11: A contender whose driven pattern differs from its configured level loses on the resulting mismatch, even when the lines carry exactly its driven pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request pulse; held as pending until granted |
| level | input | W | Configured priority level; lower value wins; hold stable during a window |
| arb_phase | input | 1 | Arbitration window strobe from the bus master |
| line_in | input | W | Sensed state of the shared arbitration lines |
| pull_low | output | W | Per-line pull-down enable for the external open-drain buffers |
| grant | output | 1 | Won the last window |
| lost | output | 1 | Contended in the last window and lost |

## Verification
Four contenders share one wired-AND bus. The bench sweeps every one of the 16 request masks across 15 rotations of distinct levels. It predicts the settled line value, each contender's settled pull-down pattern, and the winner, while its own model carries forward the losers' pending requests. These patterns separate a correct lowest-value resolution from one that yields too early, releases the wrong bits, or drops a losing request.

Directed windows add three cases:
- a contender at the idle level 4'b1111;
- a pair in which an early mismatch on a high bit must not cost the eventual winner;
- a faulty contender that drives 0 while configured for level 2.

// File: rtl/prio_arb_node.sv
module prio_arb_node #(
  parameter int            W    = 4,
  parameter logic [W-1:0]  FLIP = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic [W-1:0] level,
  input  logic         arb_phase,
  input  logic [W-1:0] line_in,
  output logic [W-1:0] pull_low,
  output logic         grant,
  output logic         lost
);

  localparam logic [W-1:0] IDLE_LINES = '1;

  logic         pending_q, phase_q, part_q, win_q;
  logic [W-1:0] yield_q, yield_d, drive_lvl;
  logic         beaten;

  wire active    = (req | pending_q) & arb_phase;
  wire phase_end = phase_q & ~arb_phase;

  assign drive_lvl = level ^ FLIP;
  assign pull_low  = active ? (~drive_lvl & ~yield_q) : '0;

  always_comb begin
    beaten = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      yield_d[i] = beaten;
      if (drive_lvl[i] && !line_in[i]) beaten = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      phase_q   <= 1'b0;
      part_q    <= 1'b0;
      win_q     <= 1'b0;
      yield_q   <= '0;
      grant     <= 1'b0;
      lost      <= 1'b0;
    end else begin
      phase_q   <= arb_phase;
      pending_q <= req | (pending_q & ~(phase_end & part_q & win_q));
      yield_q   <= active ? yield_d : '0;
      if (active) begin
        part_q <= 1'b1;
        win_q  <= (line_in == level) && (level != IDLE_LINES);
      end else if (!arb_phase) begin
        part_q <= 1'b0;
        win_q  <= 1'b0;
      end
      if (phase_end) begin
        grant <= part_q & win_q;
        lost  <= part_q & ~win_q;
      end
    end
  end

  AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && lost));                                                  // R8

  AST_UPDATE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant != $past(grant)) || (lost != $past(lost)))
      |-> ($past(phase_q) && !$past(arb_phase)));                      // R6

  AST_NO_IDLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> ($past(level) != IDLE_LINES));                     // R9

  AST_LOSER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost) |-> pending_q);                                         // R10

endmodule

// File: tb/test_prio_arb_node.sv
module test_prio_arb_node;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arb = 1'b0;
  logic [NP-1:0] req_v = '0;
  logic [3:0] lvl [NP];
  logic [3:0] pl [NP];
  logic [NP-1:0] gr, ls;
  logic f_req = 1'b0;
  logic [3:0] f_lvl = 4'd2;
  logic [3:0] f_pull;
  logic f_gr, f_ls;
  logic [3:0] line;

  int n_chk = 0;
  int n_err = 0;
  logic done = 1'b0;

  logic [NP-1:0] pend = '0;
  logic [NP-1:0] prev_g = '0, prev_l = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign line = ~(pl[0] | pl[1] | pl[2] | pl[3] | f_pull);

  for (genvar k = 0; k < NP; k++) begin : g_peer
    prio_arb_node #(.W(4)) i_peer (
      .clk(clk), .rst_n(rst_n), .req(req_v[k]), .level(lvl[k]),
      .arb_phase(arb), .line_in(line), .pull_low(pl[k]),
      .grant(gr[k]), .lost(ls[k]));
  end

  prio_arb_node #(.W(4), .FLIP(4'b0010)) i_prio_arb_node (
    .clk(clk), .rst_n(rst_n), .req(f_req), .level(f_lvl),
    .arb_phase(arb), .line_in(line), .pull_low(f_pull),
    .grant(f_gr), .lost(f_ls));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; req_v = '0; f_req = 1'b0; arb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    pend = '0; prev_g = '0; prev_l = '0;
    for (int k = 0; k < NP; k++) begin
      chk("R1 pull", pl[k], 0); chk("R1 grant", gr[k], 0); chk("R1 lost", ls[k], 0);
    end
    chk("R1 fault pull", f_pull, 0);
  endtask

  function automatic logic [3:0] settled_pull(input logic [3:0] l, input logic [3:0] b);
    logic [3:0] ym = '0;
    logic hit = 1'b0;
    for (int j = 3; j >= 0; j--) begin
      ym[j] = hit;
      if (l[j] && !b[j]) hit = 1'b1;
    end
    return ~l & ~ym;
  endfunction

  task automatic run_phase(input logic [NP-1:0] mask);
    logic [NP-1:0] part, eg, el;
    logic [4:0] mn;
    logic [3:0] bus;
    @(negedge clk); req_v = mask;
    @(negedge clk); req_v = '0; arb = 1'b1;
    part = mask | pend;
    mn = 5'd16;
    for (int k = 0; k < NP; k++)
      if (part[k] && {1'b0, lvl[k]} < mn) mn = {1'b0, lvl[k]};
    bus = (mn == 5'd16) ? 4'hF : mn[3:0];
    for (int k = 0; k < NP; k++) begin
      eg[k] = part[k] && (lvl[k] == bus) && (lvl[k] != 4'hF);
      el[k] = part[k] && !eg[k];
    end
    repeat (3) @(negedge clk);
    for (int k = 0; k < NP; k++) begin
      chk("R6 held grant", gr[k], prev_g[k]);
      chk("R6 held lost", ls[k], prev_l[k]);
    end
    repeat (3) @(negedge clk);
    chk("R4 settled lines", line, bus);
    for (int k = 0; k < NP; k++)
      chk(part[k] ? "R3 R4 settled pull" : "R2 idle pull", pl[k],
          part[k] ? settled_pull(lvl[k], bus) : 4'h0);
    repeat (2) @(negedge clk);
    arb = 1'b0;
    chk("R6 no early update", gr, prev_g);
    @(negedge clk);
    for (int k = 0; k < NP; k++) begin
      chk("R5 R7 grant", gr[k], eg[k]);
      chk("R5 R8 lost", ls[k], el[k]);
      chk("R2 released", pl[k], 0);
    end
    prev_g = eg; prev_l = el;
    pend = part & ~eg;
  endtask

  initial begin
    for (int k = 0; k < NP; k++) lvl[k] = 4'(k);
    do_reset();

    for (int s = 0; s < 15; s++) begin
      for (int k = 0; k < NP; k++) lvl[k] = 4'((s + 4*k) % 15);
      for (int m = 0; m < 16; m++) run_phase(4'(m));
    end
    while (pend != '0) run_phase('0);

    lvl[0] = 4'd6; lvl[1] = 4'd5; lvl[2] = 4'd14; lvl[3] = 4'd13;
    run_phase(4'b0011);
    chk("R4 yield pair", {gr[1], ls[0]}, 2'b11);
    lvl[0] = 4'd4; lvl[1] = 4'd8;
    run_phase(4'b0011);
    chk("R5 early mismatch", {gr[0], ls[1]}, 2'b11);

    lvl[0] = 4'd3; lvl[1] = 4'd7;
    run_phase(4'b0011);
    chk("R10 first lost", ls[1], 1);
    run_phase(4'b0000);
    chk("R10 retry win", gr[1], 1);

    lvl[3] = 4'hF;
    run_phase(4'b1000);
    chk("R9 idle level lost", {gr[3], ls[3]}, 2'b01);

    do_reset();

    lvl[0] = 4'd1;
    @(negedge clk); f_req = 1'b1; req_v = 4'b0001;
    @(negedge clk); f_req = 1'b0; req_v = '0; arb = 1'b1;
    repeat (6) @(negedge clk);
    chk("R11 faulty drives zero", line, 4'h0);
    repeat (2) @(negedge clk); arb = 1'b0;
    @(negedge clk);
    chk("R11 faulty lost", {f_gr, f_ls}, 2'b01);
    chk("R11 peer mismatch", {gr[0], ls[0]}, 2'b01);

    @(negedge clk); arb = 1'b1;
    repeat (6) @(negedge clk);
    chk("R11 retry lines", line, 4'h0);
    repeat (2) @(negedge clk); arb = 1'b0;
    @(negedge clk);
    chk("R11 faulty lost again", {f_gr, f_ls}, 2'b01);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule